// File: doc/BRIEF.md
# Long-Latency Load Flush Controller

This block sits beside the fetch and issue logic of a core that runs several hardware threads at once. It keeps one tracked load per thread. When that load looks like a long miss, the block removes the thread's instructions from the shared window and stops the thread from fetching. A load looks like a long miss when it has been outstanding too long, or when a second-level cache or translation miss is reported for it. The rest of the pipeline performs the squash. This block only decides which thread to flush, from which sequence number, and when fetch for that thread may restart.

Four trigger policies are selectable at run time:
- Age only.
- Miss report.
- Age plus a shared resource running out.
- Stop fetch at once on age, then flush only once a resource runs out.

The flush point is also selectable per load. The block never blocks the last thread that is still running. It lifts a block as soon as the cache signals that the fill has begun, which is one cycle before the data is usable.

Top module: `llflush_ctrl`

## Requirements
- R1: While `rst_n` is low, `flush_valid`, every `fetch_block` bit and every `fetch_resume` bit are 0.
- R2: In age mode (`cfg_trig_mode`=0), a load captured at clock edge E0 causes a flush request for its thread after edge E0+DELAY_L+2. Until then there is no request.
- R3: In miss mode (`cfg_trig_mode`=1), a report on the second-level miss port or on the translation miss port triggers the flush. The report must match both the thread and the tag of the tracked load. The flush request appears after the edge that samples the report. Load age alone never triggers in this mode.
- R4: A step that would block a thread is held back while NUM_THR-1 threads are already blocked. Such a step is a flush or a fetch stop. The held thread proceeds once another thread's block is lifted.
- R5: A flushed thread keeps its `fetch_block` bit at 1 from the cycle `flush_valid` names it until a return event for that thread with the tracked tag. A return with any other tag has no effect.
- R6: A return event is marked as the start of a two-cycle fill. It is sampled at edge R. In the cycle after R, the thread's `fetch_block` bit is 0 and its `fetch_resume` bit is 1 for exactly one cycle.
- R7: `flush_seq` follows the `cfg_flush_pt` value sampled with the load. The codes are:
  - 0: the consumer sequence.
  - 1: the load sequence plus one.
  - 2: the load sequence plus OFS_NEAR.
  - 3: the load sequence plus OFS_FAR.
  - 4: the branch sequence.
  - 5 to 7: the same as code 0.

  All sums wrap modulo 2^SEQ_W.
- R8: In selective mode (`cfg_trig_mode`=2), an aged load flushes only while some `rsrc_full` bit is 1. No fetch stop happens before the flush.
- R9: In stall-then-flush mode (`cfg_trig_mode`=3), an aged load sets the thread's `fetch_block` bit after edge E0+DELAY_L+2 without a flush. A flush for that thread follows the edge at which some `rsrc_full` bit is sampled 1.
- R10: At most one flush request is made per cycle. Among threads ready in the same cycle, the lowest thread index is served first.
- R11: A load that returns before triggering leaves no effect, and the next load on that thread is timed from its own issue. An issue for a thread that is already tracking a load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trig_mode | input | 2 | Trigger policy: 0 age, 1 miss, 2 selective, 3 stall-then-flush |
| cfg_flush_pt | input | 3 | Flush point code, sampled with each load issue |
| iss_valid | input | 1 | Load issue event |
| iss_thr | input | $clog2(NUM_THR) | Issuing thread |
| iss_tag | input | TAG_W | Load tag |
| iss_seq | input | SEQ_W | Sequence number of the load |
| iss_use_seq | input | SEQ_W | Sequence number of the first consumer |
| iss_br_seq | input | SEQ_W | Sequence number of the next branch |
| l2m_valid | input | 1 | Second-level cache miss report |
| l2m_thr | input | $clog2(NUM_THR) | Thread of the miss |
| l2m_tag | input | TAG_W | Load tag of the miss |
| tlbm_valid | input | 1 | Translation miss report |
| tlbm_thr | input | $clog2(NUM_THR) | Thread of the translation miss |
| tlbm_tag | input | TAG_W | Load tag of the translation miss |
| ret_valid | input | 1 | Fill start for a load; data is usable two cycles later |
| ret_thr | input | $clog2(NUM_THR) | Thread of the returning load |
| ret_tag | input | TAG_W | Tag of the returning load |
| rsrc_full | input | NRES | One bit per shared resource that is exhausted |
| flush_valid | output | 1 | Flush request |
| flush_thr | output | $clog2(NUM_THR) | Thread to flush |
| flush_seq | output | SEQ_W | First sequence number to remove |
| fetch_block | output | NUM_THR | Fetch blocked, one bit per thread |
| fetch_resume | output | NUM_THR | One-cycle pulse when a block is lifted |

## Verification
A per-thread state that is wrong shows up at the ports in one of two ways. A flush may come a cycle early or late against the issue edge. A `fetch_block` bit may rise or fall on the wrong edge. Both are seen within DELAY_L+3 cycles of the load issue. A wrong blocked count breaks the rule that keeps one thread running. It shows as all `fetch_block` bits set, or as a held thread that never flushes after a release. A wrong priority shows as a different thread order in consecutive flush requests from a single resource event. A flush point captured from the wrong source shows directly on `flush_seq` in the flush cycle.

// File: rtl/llf_pkg.sv
package llf_pkg;

   typedef enum logic [1:0] {
      TRIG_AGE    = 2'd0,
      TRIG_MISS   = 2'd1,
      TRIG_SELECT = 2'd2,
      TRIG_STALL  = 2'd3
   } trig_mode_e;

   typedef enum logic [2:0] {
      FP_USE    = 3'd0,
      FP_NEXT   = 3'd1,
      FP_NEAR   = 3'd2,
      FP_FAR    = 3'd3,
      FP_BRANCH = 3'd4
   } fpoint_e;

   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_TRACK   = 3'd1,
      S_ARMED   = 3'd2,
      S_STALLED = 3'd3,
      S_FLUSHED = 3'd4
   } slot_st_e;

endpackage

// File: rtl/llf_prio_arb.sv
module llf_prio_arb #(
   parameter int N = 4,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   // Scan from the top so that the lowest requesting index is left in idx.
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/llf_slot.sv
module llf_slot
   import llf_pkg::*;
#(
   parameter int TAG_W    = 4,
   parameter int SEQ_W    = 8,
   parameter int DELAY_L  = 15,
   parameter int OFS_NEAR = 10,
   parameter int OFS_FAR  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  trig_mode_e       mode,
   input  fpoint_e          fp,
   input  logic             iss_hit,
   input  logic [TAG_W-1:0] iss_tag,
   input  logic [SEQ_W-1:0] iss_seq,
   input  logic [SEQ_W-1:0] iss_use_seq,
   input  logic [SEQ_W-1:0] iss_br_seq,
   input  logic             l2_hit,
   input  logic [TAG_W-1:0] l2_tag,
   input  logic             tlb_hit,
   input  logic [TAG_W-1:0] tlb_tag,
   input  logic             ret_hit,
   input  logic [TAG_W-1:0] ret_tag,
   input  logic             exhausted,
   input  logic             room,
   input  logic             grant,
   output logic             req,
   output logic             req_flush,
   output logic [SEQ_W-1:0] pt_seq,
   output logic             blocked,
   output logic             resume
);

   localparam int AGE_W = $clog2(DELAY_L + 2);
   localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(DELAY_L + 1);
   localparam logic [SEQ_W-1:0] NEAR_V  = SEQ_W'(OFS_NEAR);
   localparam logic [SEQ_W-1:0] FAR_V   = SEQ_W'(OFS_FAR);

   slot_st_e         st_q;
   logic [AGE_W-1:0] age_q;
   logic [TAG_W-1:0] tag_q;
   logic [SEQ_W-1:0] pt_q;
   logic             resume_q;

   logic             ret_match;
   logic             miss_match;
   logic             trig;
   logic             hot;
   logic             want;
   logic             adds_block;
   logic [SEQ_W-1:0] cap_seq;

   assign blocked    = (st_q == S_STALLED) || (st_q == S_FLUSHED);
   assign ret_match  = ret_hit && (st_q != S_IDLE) && (ret_tag == tag_q);
   assign miss_match = (l2_hit && (l2_tag == tag_q)) || (tlb_hit && (tlb_tag == tag_q));
   assign trig       = (st_q == S_TRACK) &&
                       ((mode == TRIG_MISS) ? miss_match : (age_q == AGE_TOP));
   assign hot        = trig || (st_q == S_ARMED);

   // Flush point chosen once, when the load is captured.
   always_comb begin
      case (fp)
         FP_NEXT:   cap_seq = iss_seq + SEQ_W'(1);
         FP_NEAR:   cap_seq = iss_seq + NEAR_V;
         FP_FAR:    cap_seq = iss_seq + FAR_V;
         FP_BRANCH: cap_seq = iss_br_seq;
         default:   cap_seq = iss_use_seq;
      endcase
   end

   // What this thread asks for this cycle, per trigger policy.
   always_comb begin
      want       = 1'b0;
      adds_block = 1'b1;
      req_flush  = 1'b1;
      case (mode)
         TRIG_SELECT: want = hot && exhausted;
         TRIG_STALL: begin
            if (hot) begin
               want      = 1'b1;
               req_flush = 1'b0;
            end else if (st_q == S_STALLED) begin
               want       = exhausted;
               adds_block = 1'b0;
            end
         end
         default: want = hot;
      endcase
   end

   assign req    = want && !ret_match && (!adds_block || room);
   assign pt_seq = pt_q;
   assign resume = resume_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         age_q    <= '0;
         tag_q    <= '0;
         pt_q     <= '0;
         resume_q <= 1'b0;
      end else begin
         resume_q <= ret_match && blocked;
         if (ret_match) begin
            st_q  <= S_IDLE;
            age_q <= '0;
         end else begin
            case (st_q)
               S_IDLE: begin
                  if (iss_hit) begin
                     st_q  <= S_TRACK;
                     age_q <= '0;
                     tag_q <= iss_tag;
                     pt_q  <= cap_seq;
                  end
               end
               S_TRACK: begin
                  if (age_q != AGE_TOP) age_q <= age_q + AGE_W'(1);
                  if (grant)     st_q <= req_flush ? S_FLUSHED : S_STALLED;
                  else if (trig) st_q <= S_ARMED;
               end
               S_ARMED: begin
                  if (grant) st_q <= req_flush ? S_FLUSHED : S_STALLED;
               end
               S_STALLED: begin
                  if (grant) st_q <= S_FLUSHED;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/llflush_ctrl.sv
module llflush_ctrl
   import llf_pkg::*;
#(
   parameter int NUM_THR  = 4,
   parameter int TAG_W    = 4,
   parameter int SEQ_W    = 8,
   parameter int NRES     = 2,
   parameter int DELAY_L  = 15,
   parameter int OFS_NEAR = 10,
   parameter int OFS_FAR  = 20,
   localparam int THR_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         cfg_trig_mode,
   input  logic [2:0]         cfg_flush_pt,
   input  logic               iss_valid,
   input  logic [THR_W-1:0]   iss_thr,
   input  logic [TAG_W-1:0]   iss_tag,
   input  logic [SEQ_W-1:0]   iss_seq,
   input  logic [SEQ_W-1:0]   iss_use_seq,
   input  logic [SEQ_W-1:0]   iss_br_seq,
   input  logic               l2m_valid,
   input  logic [THR_W-1:0]   l2m_thr,
   input  logic [TAG_W-1:0]   l2m_tag,
   input  logic               tlbm_valid,
   input  logic [THR_W-1:0]   tlbm_thr,
   input  logic [TAG_W-1:0]   tlbm_tag,
   input  logic               ret_valid,
   input  logic [THR_W-1:0]   ret_thr,
   input  logic [TAG_W-1:0]   ret_tag,
   input  logic [NRES-1:0]    rsrc_full,
   output logic               flush_valid,
   output logic [THR_W-1:0]   flush_thr,
   output logic [SEQ_W-1:0]   flush_seq,
   output logic [NUM_THR-1:0] fetch_block,
   output logic [NUM_THR-1:0] fetch_resume
);

   // Elaboration-time parameter checks.
   if (NUM_THR < 2) begin : g_bad_thr
      $error("llflush_ctrl: NUM_THR must be at least 2");
   end
   if (DELAY_L < 1) begin : g_bad_delay
      $error("llflush_ctrl: DELAY_L must be at least 1");
   end
   if (TAG_W < 1 || SEQ_W < 2 || NRES < 1) begin : g_bad_width
      $error("llflush_ctrl: TAG_W, SEQ_W or NRES too small");
   end
   if (OFS_NEAR < 1 || OFS_FAR < 1) begin : g_bad_ofs
      $error("llflush_ctrl: flush point offsets must be positive");
   end

   trig_mode_e         mode;
   fpoint_e            fp;
   logic               exhausted;
   logic               room;
   logic [NUM_THR-1:0] slot_req;
   logic [NUM_THR-1:0] slot_kind;
   logic [NUM_THR-1:0] slot_gnt;
   logic [NUM_THR-1:0] slot_blk;
   logic [NUM_THR-1:0] slot_res;
   logic [SEQ_W-1:0]   slot_seq [NUM_THR];
   logic               gnt_any;
   logic [THR_W-1:0]   gnt_idx;
   int unsigned        blk_cnt;

   logic               flush_valid_q;
   logic [THR_W-1:0]   flush_thr_q;
   logic [SEQ_W-1:0]   flush_seq_q;

   assign mode      = trig_mode_e'(cfg_trig_mode);
   assign fp        = fpoint_e'(cfg_flush_pt);
   assign exhausted = |rsrc_full;
   assign blk_cnt   = $countones(slot_blk);
   assign room      = blk_cnt < (NUM_THR - 1);

   for (genvar g = 0; g < NUM_THR; g++) begin : g_slot
      assign slot_gnt[g] = gnt_any && (gnt_idx == THR_W'(g));

      llf_slot #(
         .TAG_W   (TAG_W),
         .SEQ_W   (SEQ_W),
         .DELAY_L (DELAY_L),
         .OFS_NEAR(OFS_NEAR),
         .OFS_FAR (OFS_FAR)
      ) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .mode       (mode),
         .fp         (fp),
         .iss_hit    (iss_valid && (iss_thr == THR_W'(g))),
         .iss_tag    (iss_tag),
         .iss_seq    (iss_seq),
         .iss_use_seq(iss_use_seq),
         .iss_br_seq (iss_br_seq),
         .l2_hit     (l2m_valid && (l2m_thr == THR_W'(g))),
         .l2_tag     (l2m_tag),
         .tlb_hit    (tlbm_valid && (tlbm_thr == THR_W'(g))),
         .tlb_tag    (tlbm_tag),
         .ret_hit    (ret_valid && (ret_thr == THR_W'(g))),
         .ret_tag    (ret_tag),
         .exhausted  (exhausted),
         .room       (room),
         .grant      (slot_gnt[g]),
         .req        (slot_req[g]),
         .req_flush  (slot_kind[g]),
         .pt_seq     (slot_seq[g]),
         .blocked    (slot_blk[g]),
         .resume     (slot_res[g])
      );
   end

   llf_prio_arb #(
      .N(NUM_THR)
   ) u_arb (
      .req(slot_req),
      .any(gnt_any),
      .idx(gnt_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_valid_q <= 1'b0;
         flush_thr_q   <= '0;
         flush_seq_q   <= '0;
      end else begin
         flush_valid_q <= gnt_any && slot_kind[gnt_idx];
         flush_thr_q   <= gnt_idx;
         flush_seq_q   <= slot_seq[gnt_idx];
      end
   end

   assign flush_valid  = flush_valid_q;
   assign flush_thr    = flush_thr_q;
   assign flush_seq    = flush_seq_q;
   assign fetch_block  = slot_blk;
   assign fetch_resume = slot_res;

endmodule

// File: rtl/llf_checker.sv
module llf_checker #(
   parameter int NUM_THR = 4,
   localparam int THR_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ret_valid,
   input logic [THR_W-1:0]   ret_thr,
   input logic               flush_valid,
   input logic [THR_W-1:0]   flush_thr,
   input logic [NUM_THR-1:0] fetch_block,
   input logic [NUM_THR-1:0] fetch_resume
);

   // R1: outputs quiet while reset is held (checked mid-cycle).
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (!flush_valid && fetch_block == '0 && fetch_resume == '0)
            else $error("R1 outputs active during reset");
      end
   end

   // R4: at least one thread always left able to fetch.
   a_r4_one_running: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fetch_block) < NUM_THR);

   // R5: a thread named by a flush request is fetch-blocked in that cycle.
   a_r5_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> fetch_block[flush_thr]);

   for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
      // R5: a block is only lifted by a return event for that thread.
      a_r5_hold_until_return: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(fetch_block[i]) |-> $past(ret_valid && (ret_thr == THR_W'(i))));

      // R6: resume pulse marks a block lifted on this edge.
      a_r6_resume_release: assert property (@(posedge clk) disable iff (!rst_n)
         fetch_resume[i] |-> ($past(fetch_block[i]) && !fetch_block[i]));

      // R6: resume lasts exactly one cycle.
      a_r6_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         fetch_resume[i] |=> !fetch_resume[i]);
   end

endmodule

bind llflush_ctrl llf_checker #(
   .NUM_THR(NUM_THR)
) u_llf_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ret_valid   (ret_valid),
   .ret_thr     (ret_thr),
   .flush_valid (flush_valid),
   .flush_thr   (flush_thr),
   .fetch_block (fetch_block),
   .fetch_resume(fetch_resume)
);

// File: tb/llflush_ctrl_tb.sv
`timescale 1ns/1ps
module llflush_ctrl_tb;

   localparam int NUM_THR = 4;
   localparam int TAG_W   = 4;
   localparam int SEQ_W   = 8;
   localparam int NRES    = 2;
   localparam int L       = 15;
   localparam int THR_W   = 2;

   typedef struct packed {
      logic [1:0] thr;
      logic [3:0] tag;
      logic [2:0] fp;
      logic [7:0] ld;
      logic [7:0] use_s;
      logic [7:0] br;
      logic [7:0] exp_seq;
   } vec_t;

   // R7 flush point vectors: code 0 use, 1 ld+1, 2 ld+10, 3 ld+20, 4 branch, 5-7 use.
   localparam int NVEC = 8;
   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 4'd1, 3'd0, 8'd10,  8'd13,  8'd30,  8'd13},
      '{2'd1, 4'd2, 3'd1, 8'd40,  8'd50,  8'd60,  8'd41},
      '{2'd2, 4'd3, 3'd2, 8'd100, 8'd101, 8'd120, 8'd110},
      '{2'd3, 4'd4, 3'd3, 8'd200, 8'd201, 8'd210, 8'd220},
      '{2'd1, 4'd5, 3'd4, 8'd70,  8'd72,  8'd75,  8'd75},
      '{2'd2, 4'd6, 3'd3, 8'd250, 8'd251, 8'd252, 8'd14},
      '{2'd0, 4'd7, 3'd1, 8'd255, 8'd0,   8'd3,   8'd0},
      '{2'd3, 4'd8, 3'd5, 8'd5,   8'd9,   8'd12,  8'd9}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [1:0]         cfg_trig_mode = 2'd0;
   logic [2:0]         cfg_flush_pt = 3'd0;
   logic               iss_valid = 1'b0;
   logic [THR_W-1:0]   iss_thr = '0;
   logic [TAG_W-1:0]   iss_tag = '0;
   logic [SEQ_W-1:0]   iss_seq = '0;
   logic [SEQ_W-1:0]   iss_use_seq = '0;
   logic [SEQ_W-1:0]   iss_br_seq = '0;
   logic               l2m_valid = 1'b0;
   logic [THR_W-1:0]   l2m_thr = '0;
   logic [TAG_W-1:0]   l2m_tag = '0;
   logic               tlbm_valid = 1'b0;
   logic [THR_W-1:0]   tlbm_thr = '0;
   logic [TAG_W-1:0]   tlbm_tag = '0;
   logic               ret_valid = 1'b0;
   logic [THR_W-1:0]   ret_thr = '0;
   logic [TAG_W-1:0]   ret_tag = '0;
   logic [NRES-1:0]    rsrc_full = '0;
   logic               flush_valid;
   logic [THR_W-1:0]   flush_thr;
   logic [SEQ_W-1:0]   flush_seq;
   logic [NUM_THR-1:0] fetch_block;
   logic [NUM_THR-1:0] fetch_resume;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   llflush_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_trig_mode(cfg_trig_mode), .cfg_flush_pt(cfg_flush_pt),
      .iss_valid(iss_valid), .iss_thr(iss_thr), .iss_tag(iss_tag),
      .iss_seq(iss_seq), .iss_use_seq(iss_use_seq), .iss_br_seq(iss_br_seq),
      .l2m_valid(l2m_valid), .l2m_thr(l2m_thr), .l2m_tag(l2m_tag),
      .tlbm_valid(tlbm_valid), .tlbm_thr(tlbm_thr), .tlbm_tag(tlbm_tag),
      .ret_valid(ret_valid), .ret_thr(ret_thr), .ret_tag(ret_tag),
      .rsrc_full(rsrc_full),
      .flush_valid(flush_valid), .flush_thr(flush_thr), .flush_seq(flush_seq),
      .fetch_block(fetch_block), .fetch_resume(fetch_resume)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_issue(int thr, int tag, int sq, int us, int br);
      iss_valid = 1'b1; iss_thr = THR_W'(thr); iss_tag = TAG_W'(tag);
      iss_seq = SEQ_W'(sq); iss_use_seq = SEQ_W'(us); iss_br_seq = SEQ_W'(br);
      tick();
      iss_valid = 1'b0;
   endtask

   task automatic do_ret(int thr, int tag);
      ret_valid = 1'b1; ret_thr = THR_W'(thr); ret_tag = TAG_W'(tag);
      tick();
      ret_valid = 1'b0;
   endtask

   // Wait n cycles, counting any flush request seen.
   task automatic wait_quiet(int n, string req);
      int seen = 0;
      for (int k = 0; k < n; k++) begin
         tick();
         if (flush_valid) seen++;
      end
      check(req, 32'(seen), 32'd0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      #5;
      check("R1 flush_valid in reset", 32'(flush_valid), 32'd0);
      check("R1 fetch_block in reset", 32'(fetch_block), 32'd0);
      check("R1 fetch_resume in reset", 32'(fetch_resume), 32'd0);
      tick(); tick();
      rst_n = 1'b1;
      tick();

      // Table walk: age mode, R2 timing, R7 flush point, R5/R6 release.
      cfg_trig_mode = 2'd0;
      for (int v = 0; v < NVEC; v++) begin
         cfg_flush_pt = VEC[v].fp;
         do_issue(VEC[v].thr, VEC[v].tag, VEC[v].ld, VEC[v].use_s, VEC[v].br);
         wait_quiet(L + 1, "R2 no early flush");
         tick();
         check("R2 flush on time", 32'(flush_valid), 32'd1);
         check("R10 flush thread", 32'(flush_thr), 32'(VEC[v].thr));
         check("R7 flush point", 32'(flush_seq), 32'(VEC[v].exp_seq));
         check("R5 blocked with flush", 32'(fetch_block), 32'(1 << VEC[v].thr));
         tick();
         check("R10 single pulse", 32'(flush_valid), 32'd0);
         do_ret(VEC[v].thr, VEC[v].tag);
         check("R6 unblocked", 32'(fetch_block), 32'd0);
         check("R6 resume", 32'(fetch_resume), 32'(1 << VEC[v].thr));
         tick();
         check("R6 resume one cycle", 32'(fetch_resume), 32'd0);
      end

      // R11: early return leaves nothing; busy issue ignored; R5 wrong tag.
      cfg_flush_pt = 3'd0;
      do_issue(0, 9, 10, 11, 12);
      repeat (5) tick();
      do_ret(0, 9);
      check("R11 no resume for early return", 32'(fetch_resume), 32'd0);
      wait_quiet(L + 5, "R11 no flush after early return");
      check("R11 no block", 32'(fetch_block), 32'd0);
      do_issue(0, 10, 15, 20, 25);
      do_issue(0, 11, 90, 99, 95);
      wait_quiet(L, "R11 counter restarted");
      tick();
      check("R11 flush of first load", 32'(flush_valid), 32'd1);
      check("R11 busy issue ignored", 32'(flush_seq), 32'd20);
      do_ret(0, 11);
      check("R5 wrong tag ignored", 32'(fetch_block), 32'd1);
      do_ret(0, 10);
      check("R5 matching return lifts", 32'(fetch_block), 32'd0);
      tick();

      // R3: miss mode.
      cfg_trig_mode = 2'd1;
      do_issue(1, 5, 60, 61, 62);
      wait_quiet(L + 6, "R3 age ignored in miss mode");
      l2m_valid = 1'b1; l2m_thr = 2'd1; l2m_tag = 4'd6;
      tick();
      l2m_thr = 2'd2; l2m_tag = 4'd5;
      tick();
      l2m_valid = 1'b0;
      check("R3 mismatched miss ignored", 32'(flush_valid), 32'd0);
      l2m_valid = 1'b1; l2m_thr = 2'd1; l2m_tag = 4'd5;
      tick();
      l2m_valid = 1'b0;
      check("R3 L2 miss flush", 32'({flush_valid, flush_thr}), 32'({1'b1, 2'd1}));
      check("R3 flush seq", 32'(flush_seq), 32'd61);
      do_ret(1, 5);
      tick();
      do_issue(2, 3, 80, 84, 88);
      tick();
      tlbm_valid = 1'b1; tlbm_thr = 2'd2; tlbm_tag = 4'd3;
      tick();
      tlbm_valid = 1'b0;
      check("R3 TLB miss flush", 32'({flush_valid, flush_thr}), 32'({1'b1, 2'd2}));
      do_ret(2, 3);
      tick();

      // R8 selective, R10 priority, R4 keep-one.
      cfg_trig_mode = 2'd2;
      do_issue(3, 1, 1, 2, 3);
      do_issue(1, 2, 1, 2, 3);
      do_issue(2, 3, 1, 2, 3);
      do_issue(0, 4, 1, 2, 3);
      wait_quiet(L + 4, "R8 no flush without exhaustion");
      check("R8 no fetch stop", 32'(fetch_block), 32'd0);
      rsrc_full = 2'b10;
      tick();
      check("R10 first lowest", 32'({flush_valid, flush_thr}), 32'({1'b1, 2'd0}));
      tick();
      check("R10 second", 32'({flush_valid, flush_thr}), 32'({1'b1, 2'd1}));
      tick();
      check("R10 third", 32'({flush_valid, flush_thr}), 32'({1'b1, 2'd2}));
      wait_quiet(4, "R4 last thread held");
      check("R4 three blocked", 32'(fetch_block), 32'b0111);
      do_ret(1, 2);
      check("R4 not yet", 32'(flush_valid), 32'd0);
      check("R4 block after release", 32'(fetch_block), 32'b0101);
      tick();
      check("R4 held thread flushes", 32'({flush_valid, flush_thr}), 32'({1'b1, 2'd3}));
      check("R4 blocks", 32'(fetch_block), 32'b1101);
      rsrc_full = '0;
      do_ret(0, 4);
      do_ret(2, 3);
      do_ret(3, 1);
      check("R5 all released", 32'(fetch_block), 32'd0);
      tick();

      // R9 stall-then-flush.
      cfg_trig_mode = 2'd3;
      cfg_flush_pt = 3'd0;
      do_issue(2, 7, 30, 33, 40);
      repeat (L + 1) tick();
      check("R9 not stalled early", 32'(fetch_block), 32'd0);
      tick();
      check("R9 fetch stopped", 32'(fetch_block), 32'b0100);
      check("R9 no flush at stall", 32'(flush_valid), 32'd0);
      wait_quiet(3, "R9 no flush while resources free");
      rsrc_full = 2'b01;
      tick();
      rsrc_full = '0;
      check("R9 flush on exhaustion", 32'({flush_valid, flush_thr}), 32'({1'b1, 2'd2}));
      check("R9 flush seq", 32'(flush_seq), 32'd33);
      do_ret(2, 7);
      check("R6 resume after stall", 32'(fetch_resume), 32'b0100);
      tick();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule